// File: doc/BRIEF.md
# Pad tree test mode controller

This block puts a chip's input pads into a combinational tree test for manufacturing. At the first clock edge after an asynchronous reset is released, it reads a set of strap pins. From them it picks one of three operating states: normal, NAND-tree or XNOR-tree. The state then holds until the next reset.

In either tree state, two independent chains are formed. Each chain starts at its own chain input pin and runs through a fixed, ordered set of pad input-buffer outputs. Chain 1 is driven onto the interrupt output and chain 2 onto the test output. The output enable of every other pin is forced off. In the normal state, the functional output enables, interrupt and test output pass straight through.

The controller is a small state machine with four states:
- **ST_HOLD**: entered asynchronously while reset is low.
- **ST_NORMAL**, **ST_NAND**, **ST_XNOR**: the three end states.

There are four transitions:
- **HOLD_TO_NAND** and **HOLD_TO_XNOR**: taken on the first clock after reset release when the matching strap code is seen.
- **HOLD_TO_NORMAL**: taken on any other strap code.
- **STAY**: every end state loops on itself.

Any state returns to ST_HOLD when reset is asserted.

Top module: `tree_test_ctrl`

## Requirements
- R1: While rst_n is low the block is in ST_HOLD: pad_oe equals func_oe, int_out equals func_int and tout_out equals func_tout.
- R2: On the first rising clk edge after rst_n goes high, the strap code mode_strap=3'b111, tck_strap=0, ti_strap=0, texec_strap=1 selects NAND-tree mode (HOLD_TO_NAND).
- R3: On that same edge, the strap code mode_strap=3'b111, tck_strap=0, ti_strap=1, texec_strap=0 selects XNOR-tree mode (HOLD_TO_XNOR).
- R4: Any other strap combination selects normal mode (HOLD_TO_NORMAL): pad_oe equals func_oe, int_out equals func_int and tout_out equals func_tout.
- R5: Once selected, the mode stays fixed whatever the straps do, until rst_n is asserted again.
- R6: In NAND-tree or XNOR-tree mode every bit of pad_oe is 0.
- R7: In NAND-tree mode a chain computes s0 = chain input and s_k = ~(s_(k-1) & pad[k-1]) for k = 1..LEN, and drives s_LEN as its result. pad bit 0 is the element farthest from the output.
- R8: In XNOR-tree mode a chain computes s0 = chain input and s_k = ~(s_(k-1) ^ pad[k-1]), with the same ordering as R7, and drives s_LEN as its result.
- R9: In a tree mode, int_out carries the chain 1 result (ch1_in, ch1_pads) and tout_out carries the chain 2 result (ch2_in, ch2_pads). Neither chain depends on the other chain's inputs.
- R10: The chain path is combinational. A change on a chain input or pad appears on the output in the same clock cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to capture the straps |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 3 | Mode strap pins |
| tck_strap | input | 1 | Test clock pin, must be 0 for tree test |
| ti_strap | input | 1 | Test input strap |
| texec_strap | input | 1 | Execute strap |
| ch1_in | input | 1 | Chain 1 input pin (far end) |
| ch2_in | input | 1 | Chain 2 input pin (far end) |
| ch1_pads | input | CH1_LEN | Chain 1 input-buffer outputs, bit 0 farthest from output |
| ch2_pads | input | CH2_LEN | Chain 2 input-buffer outputs, bit 0 farthest from output |
| func_oe | input | OE_WIDTH | Functional output enables of the non-test pins |
| func_int | input | 1 | Functional interrupt output value |
| func_tout | input | 1 | Functional test output value |
| pad_oe | output | OE_WIDTH | Output enables sent to the pads |
| int_out | output | 1 | Interrupt pin value (chain 1 in tree mode) |
| tout_out | output | 1 | Test output pin value (chain 2 in tree mode) |

## Verification
The bench builds the block with CH1_LEN=5, CH2_LEN=4 and OE_WIDTH=6. With an odd and an even chain length, the two chains differ in the parity of their inversion, so an element count that is off by one or a wrong chain-to-pin assignment shows up. Five pads allow all 32 pad patterns of chain 1 to be swept exhaustively in both tree modes, with chain 2 driven by a different pattern alongside. The six-bit enable field is small enough that a distinct nonzero functional value shows any bit that escapes the override.

// File: rtl/tree_test_pkg.sv
package tree_test_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_NAND   = 2'd2,
        ST_XNOR   = 2'd3
    } tt_state_e;

    localparam int          MODE_W         = 3;
    localparam logic [2:0]  TREE_MODE_CODE = 3'b111;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              tck;
        logic              ti;
        logic              texec;
    } strap_s;

    function automatic tt_state_e decode_straps(input strap_s s);
        tt_state_e r;
        r = ST_NORMAL;
        if (s.mode == TREE_MODE_CODE && !s.tck) begin
            if (!s.ti && s.texec)
                r = ST_NAND;
            else if (s.ti && !s.texec)
                r = ST_XNOR;
        end
        return r;
    endfunction

endpackage

// File: rtl/tree_mode_fsm.sv
module tree_mode_fsm
    import tree_test_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  strap_s    straps,
    output tt_state_e state_q,
    output logic      tree_en,
    output logic      xnor_sel
);
    tt_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   state_d = decode_straps(straps);
            ST_NORMAL: state_d = ST_NORMAL;
            ST_NAND:   state_d = ST_NAND;
            ST_XNOR:   state_d = ST_XNOR;
            default:   state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        tree_en  = 1'b0;
        xnor_sel = 1'b0;
        unique case (state_q)
            ST_HOLD:   ;
            ST_NORMAL: ;
            ST_NAND:   tree_en = 1'b1;
            ST_XNOR: begin
                tree_en  = 1'b1;
                xnor_sel = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/tree_chain.sv
module tree_chain #(
    parameter int LEN = 8
) (
    input  logic           chain_in,
    input  logic [LEN-1:0] pads,
    input  logic           xnor_sel,
    output logic           chain_out
);
    localparam int NODES = LEN + 1;

    logic [NODES-1:0] node;

    assign node[0] = chain_in;

    for (genvar k = 0; k < LEN; k++) begin : g_elem
        logic nand_v;
        logic xnor_v;
        assign nand_v      = ~(node[k] & pads[k]);
        assign xnor_v      = ~(node[k] ^ pads[k]);
        assign node[k+1]   = xnor_sel ? xnor_v : nand_v;
    end

    assign chain_out = node[NODES-1];

endmodule

// File: rtl/tree_pin_gate.sv
module tree_pin_gate #(
    parameter int OE_WIDTH = 16
) (
    input  logic                tree_en,
    input  logic [OE_WIDTH-1:0] func_oe,
    input  logic                func_int,
    input  logic                func_tout,
    input  logic                ch1_res,
    input  logic                ch2_res,
    output logic [OE_WIDTH-1:0] pad_oe,
    output logic                int_out,
    output logic                tout_out
);
    always_comb begin
        if (tree_en) begin
            pad_oe   = '0;
            int_out  = ch1_res;
            tout_out = ch2_res;
        end else begin
            pad_oe   = func_oe;
            int_out  = func_int;
            tout_out = func_tout;
        end
    end

endmodule

// File: rtl/tree_test_ctrl.sv
module tree_test_ctrl
    import tree_test_pkg::*;
#(
    parameter int CH1_LEN  = 8,
    parameter int CH2_LEN  = 8,
    parameter int OE_WIDTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode_strap,
    input  logic                tck_strap,
    input  logic                ti_strap,
    input  logic                texec_strap,
    input  logic                ch1_in,
    input  logic                ch2_in,
    input  logic [CH1_LEN-1:0]  ch1_pads,
    input  logic [CH2_LEN-1:0]  ch2_pads,
    input  logic [OE_WIDTH-1:0] func_oe,
    input  logic                func_int,
    input  logic                func_tout,
    output logic [OE_WIDTH-1:0] pad_oe,
    output logic                int_out,
    output logic                tout_out
);
    strap_s    straps;
    tt_state_e state_q;
    logic      tree_en;
    logic      xnor_sel;
    logic      ch1_res;
    logic      ch2_res;

    assign straps = '{mode: mode_strap, tck: tck_strap, ti: ti_strap, texec: texec_strap};

    tree_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .straps   (straps),
        .state_q  (state_q),
        .tree_en  (tree_en),
        .xnor_sel (xnor_sel)
    );

    tree_chain #(.LEN(CH1_LEN)) u_chain1 (
        .chain_in  (ch1_in),
        .pads      (ch1_pads),
        .xnor_sel  (xnor_sel),
        .chain_out (ch1_res)
    );

    tree_chain #(.LEN(CH2_LEN)) u_chain2 (
        .chain_in  (ch2_in),
        .pads      (ch2_pads),
        .xnor_sel  (xnor_sel),
        .chain_out (ch2_res)
    );

    tree_pin_gate #(.OE_WIDTH(OE_WIDTH)) u_gate (
        .tree_en   (tree_en),
        .func_oe   (func_oe),
        .func_int  (func_int),
        .func_tout (func_tout),
        .ch1_res   (ch1_res),
        .ch2_res   (ch2_res),
        .pad_oe    (pad_oe),
        .int_out   (int_out),
        .tout_out  (tout_out)
    );

endmodule

// File: rtl/tree_test_chk.sv
module tree_test_chk
    import tree_test_pkg::*;
#(
    parameter int N1  = 8,
    parameter int NOE = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tt_state_e      state_q,
    input  logic [NOE-1:0] func_oe,
    input  logic [NOE-1:0] pad_oe,
    input  logic           func_int,
    input  logic           int_out,
    input  logic           ch1_in,
    input  logic [N1-1:0]  ch1_pads
);
    localparam logic N1_ODD = logic'(N1 % 2);

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD) |=> $stable(state_q));

    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NAND || state_q == ST_XNOR) |-> (pad_oe == '0));

    // R4
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL) |-> (pad_oe == func_oe && int_out == func_int));

    // R7
    nand_allone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NAND && (&ch1_pads)) |-> (int_out == (ch1_in ^ N1_ODD)));

    // R8
    xnor_allone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XNOR && (&ch1_pads)) |-> (int_out == ch1_in));

endmodule

bind tree_test_ctrl tree_test_chk #(.N1(CH1_LEN), .NOE(OE_WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .func_oe  (func_oe),
    .pad_oe   (pad_oe),
    .func_int (func_int),
    .int_out  (int_out),
    .ch1_in   (ch1_in),
    .ch1_pads (ch1_pads)
);

// File: tb/tree_test_ctrl_tb_top.sv
`timescale 1ns/1ps
module tree_test_ctrl_tb_top;
    localparam int L1 = 5;
    localparam int L2 = 4;
    localparam int OW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_strap = 3'b000;
    logic          tck_strap = 1'b0;
    logic          ti_strap = 1'b0;
    logic          texec_strap = 1'b0;
    logic          ch1_in = 1'b0;
    logic          ch2_in = 1'b0;
    logic [L1-1:0] ch1_pads = '0;
    logic [L2-1:0] ch2_pads = '0;
    logic [OW-1:0] func_oe = 6'h2D;
    logic          func_int = 1'b1;
    logic          func_tout = 1'b0;
    logic [OW-1:0] pad_oe;
    logic          int_out;
    logic          tout_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tree_test_ctrl #(.CH1_LEN(L1), .CH2_LEN(L2), .OE_WIDTH(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .tck_strap(tck_strap),
        .ti_strap(ti_strap), .texec_strap(texec_strap), .ch1_in(ch1_in), .ch2_in(ch2_in),
        .ch1_pads(ch1_pads), .ch2_pads(ch2_pads), .func_oe(func_oe), .func_int(func_int),
        .func_tout(func_tout), .pad_oe(pad_oe), .int_out(int_out), .tout_out(tout_out)
    );

    function automatic logic model(input logic x, input logic cin, input logic [31:0] p, input int n);
        logic s;
        s = cin;
        for (int k = 0; k < n; k++)
            s = x ? ~(s ^ p[k]) : ~(s & p[k]);
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [2:0] m, input logic t, input logic i, input logic e);
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap = m; tck_strap = t; ti_strap = i; texec_strap = e;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic check_pass(input string tag);
        check({tag, " oe"}, 32'(pad_oe), 32'(func_oe));
        check({tag, " int"}, 32'(int_out), 32'(func_int));
        check({tag, " tout"}, 32'(tout_out), 32'(func_tout));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap = 3'b111; tck_strap = 1'b0; ti_strap = 1'b0; texec_strap = 1'b1;
        @(posedge clk);
        #1;
        check_pass("R1 in reset");
        func_oe = 6'h12; func_int = 1'b0; func_tout = 1'b1;
        #1;
        check_pass("R1 in reset after change");
    endtask

    task automatic sweep(input logic x, input string tag);
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            ch1_pads = L1'(v);
            ch2_pads = L2'(v * 7 + 3);
            ch1_in = v[0] ^ v[2];
            ch2_in = ~v[1];
            #1;
            check({tag, " chain1 int_out R9"}, 32'(int_out), 32'(model(x, ch1_in, 32'(ch1_pads), L1)));
            check({tag, " chain2 tout_out R9"}, 32'(tout_out), 32'(model(x, ch2_in, 32'(ch2_pads), L2)));
            check("R6 oe forced off", 32'(pad_oe), 32'd0);
        end
    endtask

    task automatic t_nand();
        apply_reset(3'b111, 1'b0, 1'b0, 1'b1);
        check("R2 nand oe off", 32'(pad_oe), 32'd0);
        sweep(1'b0, "R7 nand");
    endtask

    task automatic t_xnor();
        apply_reset(3'b111, 1'b0, 1'b1, 1'b0);
        check("R3 xnor oe off", 32'(pad_oe), 32'd0);
        sweep(1'b1, "R8 xnor");
    endtask

    task automatic t_illegal();
        func_oe = 6'h2D; func_int = 1'b1; func_tout = 1'b0;
        apply_reset(3'b110, 1'b0, 1'b0, 1'b1);
        check_pass("R4 mode 110");
        apply_reset(3'b111, 1'b1, 1'b0, 1'b1);
        check_pass("R4 tck high");
        apply_reset(3'b111, 1'b0, 1'b1, 1'b1);
        check_pass("R4 ti1 texec1");
        apply_reset(3'b111, 1'b0, 1'b0, 1'b0);
        check_pass("R4 ti0 texec0");
    endtask

    task automatic t_hold();
        apply_reset(3'b111, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        ti_strap = 1'b1; texec_strap = 1'b0;
        repeat (4) @(negedge clk);
        ch1_pads = 5'b10110; ch1_in = 1'b1;
        #1;
        check("R5 stays nand after strap change", 32'(int_out), 32'(model(1'b0, 1'b1, 32'h16, L1)));
        check("R5 oe still off", 32'(pad_oe), 32'd0);
        mode_strap = 3'b000;
        repeat (3) @(negedge clk);
        #1;
        check("R5 stays tree after mode strap drop", 32'(pad_oe), 32'd0);
    endtask

    task automatic t_comb();
        logic prev_t;
        apply_reset(3'b111, 1'b0, 1'b1, 1'b0);
        @(posedge clk);
        #0.5;
        ch1_pads = 5'b01101; ch2_pads = 4'b1001; ch1_in = 1'b0; ch2_in = 1'b1;
        #0.5;
        check("R10 int_out settles same cycle", 32'(int_out), 32'(model(1'b1, 1'b0, 32'h0D, L1)));
        prev_t = tout_out;
        ch1_in = 1'b1;
        #0.5;
        check("R10 toggle ch1_in without clock", 32'(int_out), 32'(model(1'b1, 1'b1, 32'h0D, L1)));
        check("R9 chain2 unaffected by ch1_in", 32'(tout_out), 32'(prev_t));
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_nand();
        t_xnor();
        t_illegal();
        t_hold();
        t_comb();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule